// File: doc/BRIEF.md
# Flash Command Interface Controller

This block stands between a simple synchronous bus and a small on-chip word store split into equal blocks. Each bus write is read as a command byte (the low eight bits of the write data). One-write commands choose where reads come from: the store itself, an 8-bit status register, a few identification words, or a short query table. Two-write commands start a word program or a block erase. The second write of each supplies the target address, and for program the data as well. A countdown timer models how long the operation takes. While it runs, reads return status and almost every write is dropped.

Each block carries a protection bit that is fixed at reset by a parameter. A program or erase aimed at a protected block aborts and flags an error. An erase whose second write is not the confirm byte also aborts, with two error flags set. Error flags stay set until the clear-status command. An erase in progress can be paused and then resumed. Reads are combinational on the address, so there is no read strobe.

Status bits: 7 ready, 6 erase paused, 5 erase error, 4 program error, 1 protected-block hit. All other bits read 0. A status read puts the register on rdata[7:0] and zeros on rdata[15:8].

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the block is in store-read mode. Every word of the store reads FFFFh and status reads 0080h.
- R2: Writing FFh selects store-read mode. Any command byte that is not valid in the current state, when not busy, also returns to store-read mode.
- R3: After 70h, a read at any address returns the status register, until the next accepted command.
- R4: After 90h, ID words 0, 1 and 2 read the maker code, the device code and the block protection mask. After 98h, query words 0 to 3 read 0051h, 0052h, 0059h and the block count.
- R5: A write of 40h followed by an address/data write replaces the word with old AND data once the timer ends. While busy, status bit 7 is 0 and every read returns status.
- R6: A write of 20h followed by a D0h write whose address falls in a block sets every word of that block to FFFFh. Other blocks are left as they were.
- R7: If the write after 20h is not D0h, status bits 5 and 4 both set and the store is left unchanged.
- R8: An erase aimed at a protected block sets bits 5 and 1. A program aimed at one sets bits 4 and 1. In both cases the store is left unchanged.
- R9: While busy, only 70h and B0h are acted on. Any other write is ignored, so after completion reads still return status.
- R10: B0h during an erase pauses it, setting bits 6 and 7. In the paused state the read-mode commands work and D0h resumes the erase to completion.
- R11: Error bits 5, 4 and 1 stay set until 50h is written, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on a clock edge |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data; bits 7:0 carry the command byte |
| rdata | output | 16 | Read data from the selected source |

## Verification
The assertions check on every cycle that:
- reads during an operation show a not-ready status with a zero upper byte;
- a bad confirm or a protected target raises the right flags on the next cycle;
- error flags are kept unless clear-status arrives;
- the paused state always reports ready.

The bench scenarios check the rest: the AND merge of program data, that an erase covers exactly one block, that commands written while busy are dropped, and the data seen before and after pause and resume.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {RD_ARRAY, RD_STATUS, RD_ID, RD_QUERY} rd_mode_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ERS_SETUP, ST_PRG_SETUP, ST_PRG_BUSY, ST_ERS_BUSY, ST_ERS_PAUSE
  } cmd_state_e;

  localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
  localparam logic [7:0] OP_READ_STAT  = 8'h70;
  localparam logic [7:0] OP_READ_ID    = 8'h90;
  localparam logic [7:0] OP_QUERY      = 8'h98;
  localparam logic [7:0] OP_ERS_SETUP  = 8'h20;
  localparam logic [7:0] OP_PRG_SETUP  = 8'h40;
  localparam logic [7:0] OP_PAUSE      = 8'hB0;
  localparam logic [7:0] OP_CONFIRM    = 8'hD0;
  localparam logic [7:0] OP_CLR_STAT   = 8'h50;

  function automatic logic [15:0] merge_program(input logic [15:0] old_w, input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic [15:0] id_word(input logic [1:0] idx, input logic [15:0] maker,
                                          input logic [15:0] device, input logic [15:0] prot);
    case (idx)
      2'd0:    return maker;
      2'd1:    return device;
      2'd2:    return prot;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] query_word(input logic [3:0] idx, input int unsigned nblk,
                                             input int unsigned bwords, input int unsigned pcyc,
                                             input int unsigned ecyc);
    case (idx)
      4'd0:    return 16'h0051;
      4'd1:    return 16'h0052;
      4'd2:    return 16'h0059;
      4'd3:    return 16'(nblk);
      4'd4:    return 16'(bwords);
      4'd5:    return 16'(pcyc);
      4'd6:    return 16'(ecyc);
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/fc_op_timer.sv
module fc_op_timer #(
  parameter int unsigned PRG_CYCLES = 6,
  parameter int unsigned ERS_CYCLES = 20,
  localparam int unsigned MAXC = (PRG_CYCLES > ERS_CYCLES) ? PRG_CYCLES : ERS_CYCLES,
  localparam int unsigned CNT_W = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_erase,
  input  logic run,
  output logic done
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load) cnt_q <= load_erase ? CNT_W'(ERS_CYCLES - 1) : CNT_W'(PRG_CYCLES - 1);
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = run && (cnt_q == '0);
endmodule

// File: rtl/fc_storage.sv
module fc_storage #(
  parameter int unsigned NUM_BLOCKS  = 4,
  parameter int unsigned BLOCK_WORDS = 8,
  localparam int unsigned NUM_WORDS = NUM_BLOCKS * BLOCK_WORDS,
  localparam int unsigned ADDR_W = $clog2(NUM_WORDS),
  localparam int unsigned OFS_W = $clog2(BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_prg,
  input  logic              do_ers,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [15:0]       op_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data
);
  import fc_pkg::*;
  logic [15:0] words [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
    logic [15:0] q;
    logic hit_word, hit_blk;
    assign hit_word = (op_addr == MY_ADDR);
    assign hit_blk  = (op_addr[ADDR_W-1:OFS_W] == MY_ADDR[ADDR_W-1:OFS_W]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 16'hFFFF;
      else if (do_ers && hit_blk) q <= 16'hFFFF;
      else if (do_prg && hit_word) q <= merge_program(q, op_data);
    end
    assign words[g] = q;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/fc_cmd_fsm.sv
module fc_cmd_fsm #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [15:0]         wdata,
  input  logic                blk_prot,
  input  logic                timer_done,
  output fc_pkg::rd_mode_e    mode_o,
  output logic [7:0]          status_o,
  output logic                busy_o,
  output logic [ADDR_W-1:0]   op_addr_o,
  output logic [15:0]         op_data_o,
  output logic                timer_load_o,
  output logic                timer_erase_o,
  output logic                timer_run_o,
  output logic                bad_confirm_o,
  output logic                prot_hit_o,
  output logic                do_prg_o,
  output logic                do_ers_o
);
  import fc_pkg::*;
  cmd_state_e state_q;
  rd_mode_e   mode_q;
  logic       err_ers_q, err_prg_q, err_prot_q;
  logic [7:0] cmd;

  assign cmd = wdata[7:0];

  logic ers_wr, prg_wr;
  assign ers_wr = (state_q == ST_ERS_SETUP) && wr_en;
  assign prg_wr = (state_q == ST_PRG_SETUP) && wr_en;

  assign bad_confirm_o = ers_wr && (cmd != OP_CONFIRM);
  assign prot_hit_o    = ((ers_wr && cmd == OP_CONFIRM) || prg_wr) && blk_prot;
  assign timer_load_o  = ((ers_wr && cmd == OP_CONFIRM) || prg_wr) && !blk_prot;
  assign timer_erase_o = (state_q == ST_ERS_SETUP);
  assign busy_o        = (state_q == ST_PRG_BUSY) || (state_q == ST_ERS_BUSY);
  assign timer_run_o   = busy_o;
  assign do_prg_o      = (state_q == ST_PRG_BUSY) && timer_done;
  assign do_ers_o      = (state_q == ST_ERS_BUSY) && timer_done;
  assign mode_o        = mode_q;
  assign status_o      = {!busy_o, state_q == ST_ERS_PAUSE, err_ers_q, err_prg_q,
                          2'b00, err_prot_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= RD_ARRAY;
      err_ers_q  <= 1'b0;
      err_prg_q  <= 1'b0;
      err_prot_q <= 1'b0;
      op_addr_o  <= '0;
      op_data_o  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (wr_en) begin
          case (cmd)
            OP_READ_ARRAY: mode_q <= RD_ARRAY;
            OP_READ_STAT:  mode_q <= RD_STATUS;
            OP_READ_ID:    mode_q <= RD_ID;
            OP_QUERY:      mode_q <= RD_QUERY;
            OP_CLR_STAT: begin
              err_ers_q  <= 1'b0;
              err_prg_q  <= 1'b0;
              err_prot_q <= 1'b0;
            end
            OP_ERS_SETUP:  state_q <= ST_ERS_SETUP;
            OP_PRG_SETUP:  state_q <= ST_PRG_SETUP;
            default:       mode_q <= RD_ARRAY;
          endcase
        end
        ST_ERS_SETUP: if (wr_en) begin
          mode_q <= RD_STATUS;
          if (cmd != OP_CONFIRM) begin
            err_ers_q <= 1'b1;
            err_prg_q <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (blk_prot) begin
            err_ers_q  <= 1'b1;
            err_prot_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            op_addr_o <= addr;
            state_q   <= ST_ERS_BUSY;
          end
        end
        ST_PRG_SETUP: if (wr_en) begin
          mode_q <= RD_STATUS;
          if (blk_prot) begin
            err_prg_q  <= 1'b1;
            err_prot_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            op_addr_o <= addr;
            op_data_o <= wdata;
            state_q   <= ST_PRG_BUSY;
          end
        end
        ST_PRG_BUSY: begin
          if (wr_en && cmd == OP_READ_STAT) mode_q <= RD_STATUS;
          if (timer_done) state_q <= ST_IDLE;
        end
        ST_ERS_BUSY: begin
          if (timer_done) state_q <= ST_IDLE;
          else if (wr_en && cmd == OP_PAUSE) begin
            state_q <= ST_ERS_PAUSE;
            mode_q  <= RD_STATUS;
          end else if (wr_en && cmd == OP_READ_STAT) mode_q <= RD_STATUS;
        end
        ST_ERS_PAUSE: if (wr_en) begin
          case (cmd)
            OP_READ_ARRAY: mode_q <= RD_ARRAY;
            OP_READ_STAT:  mode_q <= RD_STATUS;
            OP_READ_ID:    mode_q <= RD_ID;
            OP_QUERY:      mode_q <= RD_QUERY;
            OP_CONFIRM: begin
              state_q <= ST_ERS_BUSY;
              mode_q  <= RD_STATUS;
            end
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int unsigned NUM_BLOCKS  = 4,
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned PRG_CYCLES  = 6,
  parameter int unsigned ERS_CYCLES  = 20,
  parameter logic [NUM_BLOCKS-1:0] PROT_INIT = 4'b1000,
  parameter logic [15:0] MAKER_CODE  = 16'h00A5,
  parameter logic [15:0] DEVICE_CODE = 16'h1234,
  localparam int unsigned ADDR_W = $clog2(NUM_BLOCKS * BLOCK_WORDS),
  localparam int unsigned OFS_W  = $clog2(BLOCK_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  import fc_pkg::*;

  rd_mode_e          mode;
  logic [7:0]        status;
  logic              busy, blk_prot, timer_done, timer_load, timer_erase, timer_run;
  logic              bad_confirm, prot_hit, do_prg, do_ers, op_done;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_data, store_rd;

  assign blk_prot = PROT_INIT[addr[ADDR_W-1:OFS_W]];
  assign op_done  = do_prg || do_ers;

  fc_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .blk_prot(blk_prot), .timer_done(timer_done), .mode_o(mode), .status_o(status),
    .busy_o(busy), .op_addr_o(op_addr), .op_data_o(op_data), .timer_load_o(timer_load),
    .timer_erase_o(timer_erase), .timer_run_o(timer_run), .bad_confirm_o(bad_confirm),
    .prot_hit_o(prot_hit), .do_prg_o(do_prg), .do_ers_o(do_ers)
  );

  fc_op_timer #(.PRG_CYCLES(PRG_CYCLES), .ERS_CYCLES(ERS_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_erase(timer_erase),
    .run(timer_run), .done(timer_done)
  );

  fc_storage #(.NUM_BLOCKS(NUM_BLOCKS), .BLOCK_WORDS(BLOCK_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .do_prg(do_prg), .do_ers(do_ers), .op_addr(op_addr),
    .op_data(op_data), .rd_addr(addr), .rd_data(store_rd)
  );

  always_comb begin
    if (busy) rdata = {8'h00, status};
    else begin
      case (mode)
        RD_ARRAY:  rdata = store_rd;
        RD_STATUS: rdata = {8'h00, status};
        RD_ID:     rdata = id_word(addr[1:0], MAKER_CODE, DEVICE_CODE, 16'(PROT_INIT));
        default:   rdata = query_word(addr[3:0], NUM_BLOCKS, BLOCK_WORDS, PRG_CYCLES, ERS_CYCLES);
      endcase
    end
  end
endmodule

// File: rtl/fc_chk.sv
module fc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic [7:0]  status,
  input logic        busy,
  input logic        bad_confirm,
  input logic        prot_hit,
  input logic        op_done
);
  AST_BUSY_READ_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rdata[7] == 1'b0) && (rdata[15:8] == 8'h00)); // R5
  AST_BAD_CONFIRM_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_confirm |=> status[5] && status[4]); // R7
  AST_PROT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |=> !busy && status[1]); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] && !(wr_en && wdata[7:0] == 8'h50) |=> status[5]); // R11
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> status[7]); // R6
  AST_PAUSE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[7] && !busy); // R10
endmodule

bind flash_cmd_ctrl fc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
  .status(status), .busy(busy), .bad_confirm(bad_confirm), .prot_hit(prot_hit),
  .op_done(op_done)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
module flash_cmd_ctrl_tb_top;
  localparam int ADDR_W = 5;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  int checks = 0, failures = 0;
  logic mon_req = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  flash_cmd_ctrl dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                        .wdata(wdata), .rdata(rdata));

  always @(negedge clk) begin
    if (mon_req && sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      checks++;
      if (rdata !== it.exp) begin
        failures++;
        $display("FAIL %s: rdata=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(posedge clk); #1 wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string tag);
    exp_t it;
    @(posedge clk); #1 addr = a; mon_req = 1'b1;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1 mon_req = 1'b0;
  endtask

  task automatic wait_ready(input string tag);
    int n = 0;
    do begin @(negedge clk); n++; end while (rdata[7] !== 1'b1 && n < 500);
    if (n >= 500) begin
      checks++; failures++;
      $display("FAIL %s: ready stayed %b expected 1", tag, rdata[7]);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_rd(5'd3, 16'hFFFF, "R1 store after reset");
    bus_wr(5'd0, 16'h0070);
    expect_rd(5'd0, 16'h0080, "R1 status after reset");
    expect_rd(5'd17, 16'h0080, "R3 status at other address");
    // program and AND merge
    bus_wr(5'd0, 16'h0040); bus_wr(5'd3, 16'h5A3C);
    expect_rd(5'd3, 16'h0000, "R5 busy read shows status");
    wait_ready("R5 program end");
    expect_rd(5'd12, 16'h0080, "R5 status after program");
    bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd3, 16'h5A3C, "R2 R5 programmed word");
    bus_wr(5'd0, 16'h0040); bus_wr(5'd3, 16'h0FF0); wait_ready("R5 second program");
    bus_wr(5'd0, 16'h0040); bus_wr(5'd9, 16'h1111); wait_ready("R5 block1 program");
    bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd3, 16'h0A30, "R5 AND merge");
    // id and query
    bus_wr(5'd0, 16'h0090);
    expect_rd(5'd0, 16'h00A5, "R4 maker");
    expect_rd(5'd1, 16'h1234, "R4 device");
    expect_rd(5'd2, 16'h0008, "R4 protection mask");
    bus_wr(5'd0, 16'h0098);
    expect_rd(5'd0, 16'h0051, "R4 query 0");
    expect_rd(5'd1, 16'h0052, "R4 query 1");
    expect_rd(5'd2, 16'h0059, "R4 query 2");
    expect_rd(5'd3, 16'h0004, "R4 query block count");
    bus_wr(5'd0, 16'h0012);
    expect_rd(5'd3, 16'h0A30, "R2 invalid code back to store");
    // erase block 0
    bus_wr(5'd0, 16'h0020); bus_wr(5'd2, 16'h00D0); wait_ready("R6 erase end");
    bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd3, 16'hFFFF, "R6 erased word");
    expect_rd(5'd9, 16'h1111, "R6 other block kept");
    // bad confirm
    bus_wr(5'd0, 16'h0020); bus_wr(5'd9, 16'h0033);
    expect_rd(5'd0, 16'h00B0, "R7 bad confirm status");
    bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd9, 16'h1111, "R7 store unchanged");
    bus_wr(5'd0, 16'h0070);
    expect_rd(5'd0, 16'h00B0, "R11 errors sticky");
    bus_wr(5'd0, 16'h0050);
    expect_rd(5'd0, 16'h0080, "R11 clear status");
    // protected block 3
    bus_wr(5'd0, 16'h0040); bus_wr(5'd24, 16'h0000);
    expect_rd(5'd0, 16'h0092, "R8 program protected");
    bus_wr(5'd0, 16'h0050);
    bus_wr(5'd0, 16'h0020); bus_wr(5'd25, 16'h00D0);
    expect_rd(5'd0, 16'h00A2, "R8 erase protected");
    bus_wr(5'd0, 16'h0050); bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd24, 16'hFFFF, "R8 protected data kept");
    // writes while busy ignored
    bus_wr(5'd0, 16'h0040); bus_wr(5'd10, 16'h00FF);
    bus_wr(5'd0, 16'h00FF); bus_wr(5'd0, 16'h0090);
    wait_ready("R9 program end");
    expect_rd(5'd10, 16'h0080, "R9 busy writes dropped");
    bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd10, 16'h00FF, "R9 program result");
    // pause and resume erase of block 1
    bus_wr(5'd0, 16'h0020); bus_wr(5'd8, 16'h00D0);
    bus_wr(5'd0, 16'h00B0);
    expect_rd(5'd0, 16'h00C0, "R10 paused status");
    bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd9, 16'h1111, "R10 read store while paused");
    bus_wr(5'd0, 16'h00D0);
    expect_rd(5'd0, 16'h0000, "R10 resumed busy");
    wait_ready("R10 erase end");
    expect_rd(5'd0, 16'h0080, "R10 status after resume");
    bus_wr(5'd0, 16'h00FF);
    expect_rd(5'd9, 16'hFFFF, "R10 erase completed");
    expect_rd(5'd10, 16'hFFFF, "R10 whole block erased");
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule